// File: doc/BRIEF.md
# GF(4096) Tower-Field Multiplier

This block multiplies two elements of the finite field GF(2^12). Each element is held as a pair of GF(64) digits, and the product is formed in a tower construction rather than in a single degree-12 polynomial basis. The base field GF(64) is reduced by x^6 + x + 1. The extension is quadratic over that base, with y^2 + y + c, where c is the base-field constant 0x21 (A^-1 for the generator A). Three base-field products and one constant base-field product make up a full multiply.

A second mode serves the generator step that Reed-Solomon table builders use. In this mode the block multiplies one operand by the fixed element 0xE01 and ignores the other operand. Zero is the one exception: it maps to 1. This lets a table walk begin from zero. The output is a one-cycle registered pipeline stage with a valid strobe. A parameter can make the stage combinational instead.

Top module: `gf4k_mul`

## Requirements
- R1: In general mode (`mode`=0), `product` = (H << 6) ^ L. H = m(ah^al, bh^bl) ^ m(al, bl) and L = m(m(ah, bh), 0x21) ^ m(al, bl). Here ah/al are bits [11:6]/[5:0] of `op_a`, bh/bl are the same halves of `op_b`, and m is GF(64) multiplication.
- R2: GF(64) multiplication reduces by x^6+x+1. An overflow into bit 6 folds back as XOR with 0x43. For example, 0x020 times 0x002 gives 0x003.
- R3: In generator mode (`mode`=1) with a nonzero `op_a`, `product` is `op_a` times 0xE01 under the R1 rule. `op_b` has no effect on the result.
- R4: In generator mode, an `op_a` of 0 yields `product` = 0x001.
- R5: In general mode, a zero in either operand yields `product` = 0x000.
- R6: In general mode, an `op_b` of 0x001 yields `product` = `op_a`.
- R7: General-mode multiplication is commutative: a*b equals b*a.
- R8: With the default registered stage, `out_valid` equals `in_valid` one clock later. While `in_valid` is low, `product` holds its last value.
- R9: A synchronous active-high `rst` clears `out_valid` and `product` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 1 | 0 = general multiply, 1 = generator step by 0xE01 |
| op_a | input | 12 | First operand (generator-mode input) |
| op_b | input | 12 | Second operand (ignored in generator mode) |
| out_valid | output | 1 | Product valid |
| product | output | 12 | Field product |

## Verification
Reductions in both tower layers are hard to reach from the ports. These are overflows in the base field, and in the constant multiply by 0x21 that the high-half cross term feeds. Operands with only low digits never exercise the constant path. The stimulus therefore mixes directed vectors with all-ones high digits and single-bit high digits, plus several thousand random operand pairs in both modes. Each vector is compared against a behavioural carry-less-multiply reference. A second hard case is the zero input in generator mode. It must bypass the multiplier, so it is driven both right after reset and between nonzero steps, with a changing `op_b`.

// File: rtl/gf4k_pkg.sv
package gf4k_pkg;

    // Digit and element widths of the tower field
    localparam int HALF_W = 6;
    localparam int ELEM_W = 2 * HALF_W;

    // x^6 + x + 1 without its leading term
    localparam logic [HALF_W-1:0] BASE_POLY_LO = 6'h03;

    // Constant term of the quadratic extension
    localparam logic [HALF_W-1:0] TOWER_K = 6'h21;

    // Fixed multiplier of the generator step
    localparam logic [ELEM_W-1:0] GEN_K = 12'hE01;

    // Value returned for a zero generator-step input
    localparam logic [ELEM_W-1:0] GEN_ZERO_OUT = 12'h001;

    typedef enum logic {
        MUL_GENERAL = 1'b0,
        MUL_GENSTEP = 1'b1
    } mul_mode_e;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } gf4k_elem_t;

    typedef struct packed {
        gf4k_elem_t a;
        gf4k_elem_t b;
        logic       force_one;
    } mul_req_t;

    // Multiply a base-field digit by x, folding back bit 6
    function automatic logic [HALF_W-1:0] base_xtime(input logic [HALF_W-1:0] v);
        logic [HALF_W-1:0] s;
        s = {v[HALF_W-2:0], 1'b0};
        if (v[HALF_W-1]) begin
            s = s ^ BASE_POLY_LO;
        end
        return s;
    endfunction

endpackage

// File: rtl/gf64_mul.sv
module gf64_mul
    import gf4k_pkg::*;
#(
    parameter int W = HALF_W
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] z
);
    // Shift-and-add over W stages; stage k holds y * x^k
    logic [W-1:0] shifted [W+1];
    logic [W-1:0] acc     [W+1];

    assign shifted[0] = y;
    assign acc[0]     = '0;

    for (genvar k = 0; k < W; k++) begin : g_stage
        assign shifted[k+1] = base_xtime(shifted[k]);
        assign acc[k+1]     = acc[k] ^ (x[k] ? shifted[k] : '0);
    end

    assign z = acc[W];
endmodule

// File: rtl/gf4k_operand_sel.sv
module gf4k_operand_sel
    import gf4k_pkg::*;
(
    input  logic             mode,
    input  logic [ELEM_W-1:0] op_a,
    input  logic [ELEM_W-1:0] op_b,
    output mul_req_t         req
);
    mul_mode_e md;

    always_comb begin
        md            = mul_mode_e'(mode);
        req.a         = gf4k_elem_t'(op_a);
        req.b         = gf4k_elem_t'(op_b);
        req.force_one = 1'b0;
        if (md == MUL_GENSTEP) begin
            req.b         = gf4k_elem_t'(GEN_K);
            req.force_one = (op_a == '0);
        end
    end
endmodule

// File: rtl/gf4k_tower_core.sv
module gf4k_tower_core
    import gf4k_pkg::*;
(
    input  mul_req_t          req,
    output logic [ELEM_W-1:0] prod
);
    logic [HALF_W-1:0] sum_a, sum_b;
    logic [HALF_W-1:0] m_cross, m_low, m_high, m_scaled;
    gf4k_elem_t        res;

    assign sum_a = req.a.hi ^ req.a.lo;
    assign sum_b = req.b.hi ^ req.b.lo;

    gf64_mul #(.W(HALF_W)) u_cross (.x(sum_a),    .y(sum_b),    .z(m_cross));
    gf64_mul #(.W(HALF_W)) u_low   (.x(req.a.lo), .y(req.b.lo), .z(m_low));
    gf64_mul #(.W(HALF_W)) u_high  (.x(req.a.hi), .y(req.b.hi), .z(m_high));
    gf64_mul #(.W(HALF_W)) u_scale (.x(m_high),   .y(TOWER_K),  .z(m_scaled));

    always_comb begin
        res.hi = m_cross ^ m_low;
        res.lo = m_scaled ^ m_low;
        prod   = req.force_one ? GEN_ZERO_OUT : ELEM_W'(res);
    end
endmodule

// File: rtl/gf4k_mul.sv
module gf4k_mul
    import gf4k_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              mode,
    input  logic [ELEM_W-1:0] op_a,
    input  logic [ELEM_W-1:0] op_b,
    output logic              out_valid,
    output logic [ELEM_W-1:0] product
);
    mul_req_t          req;
    logic [ELEM_W-1:0] comb_prod;

    gf4k_operand_sel u_sel (
        .mode (mode),
        .op_a (op_a),
        .op_b (op_b),
        .req  (req)
    );

    gf4k_tower_core u_core (
        .req  (req),
        .prod (comb_prod)
    );

    if (REGISTERED) begin : g_reg
        logic              v_q;
        logic [ELEM_W-1:0] p_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                p_q <= '0;
            end else begin
                v_q <= in_valid;
                if (in_valid) begin
                    p_q <= comb_prod;
                end
            end
        end
        assign out_valid = v_q;
        assign product   = p_q;
    end else begin : g_comb
        assign out_valid = in_valid;
        assign product   = comb_prod;
    end
endmodule

// File: rtl/gf4k_mul_chk.sv
module gf4k_mul_chk
    import gf4k_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              mode,
    input logic [ELEM_W-1:0] op_a,
    input logic [ELEM_W-1:0] op_b,
    input logic              out_valid,
    input logic [ELEM_W-1:0] product
);
    if (REGISTERED) begin : g_props
        p_valid_lag_r8: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
        p_hold_r8: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(product));
        p_gen_zero_r4: assert property (@(posedge clk) disable iff (rst)
            (in_valid && mode && op_a == '0) |=> product == GEN_ZERO_OUT);
        p_zero_operand_r5: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !mode && (op_a == '0 || op_b == '0)) |=> product == '0);
        p_identity_r6: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !mode && op_b == ELEM_W'(1)) |=> product == $past(op_a));
    end
endmodule

bind gf4k_mul gf4k_mul_chk #(.REGISTERED(REGISTERED)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mode      (mode),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/gf4k_mul_bench.sv
`timescale 1ns/1ps
module gf4k_mul_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        mode = 1'b0;
    logic [11:0] op_a = '0;
    logic [11:0] op_b = '0;
    logic        out_valid;
    logic [11:0] product;

    int n_vec = 0;
    int n_bad = 0;
    bit exp_v = 1'b0;
    logic [11:0] exp_p = '0;

    always #2.5 clk = ~clk;

    gf4k_mul u_gf4k_mul (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product)
    );

    // Carry-less product then polynomial reduction by x^6+x+1
    function automatic int ref_m64(input int x, input int y);
        int p = 0;
        for (int i = 0; i < 6; i++) if ((x >> i) & 1) p ^= (y << i);
        for (int k = 10; k >= 6; k--) if ((p >> k) & 1) p ^= (32'h43 << (k - 6));
        return p & 63;
    endfunction

    function automatic int ref_mul(input int a, input int b);
        int ah = (a >> 6) & 63, al = a & 63, bh = (b >> 6) & 63, bl = b & 63;
        int h, l;
        h = ref_m64(ah ^ al, bh ^ bl) ^ ref_m64(al, bl);
        l = ref_m64(ref_m64(ah, bh), 33) ^ ref_m64(al, bl);
        return (h << 6) ^ l;
    endfunction

    function automatic int ref_op(input bit m, input int a, input int b);
        if (m) return (a == 0) ? 1 : ref_mul(a, 12'hE01);
        return ref_mul(a, b);
    endfunction

    task automatic check(input string tag, input logic [11:0] got, input logic [11:0] want);
        n_vec++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s: got %03h expected %03h", tag, got, want);
        end
    endtask

    // Called at a negedge: drive, let one edge pass, compare at next negedge
    task automatic apply(input bit v, input bit m, input int a, input int b, input string tag);
        in_valid = v; mode = m; op_a = 12'(a); op_b = 12'(b);
        @(posedge clk);
        exp_v = v;
        if (v) exp_p = 12'(ref_op(m, a, b));
        @(negedge clk);
        check({tag, " valid"}, {11'd0, out_valid}, {11'd0, exp_v});
        check({tag, " product"}, product, exp_p);
    endtask

    initial begin : watchdog
        #(5ns * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        logic [11:0] keep;
        repeat (3) @(negedge clk);
        check("R9 reset valid", {11'd0, out_valid}, 12'd0);
        check("R9 reset product", product, 12'd0);
        rst = 1'b0;

        // R4: zero generator input straight after reset
        apply(1, 1, 0, 12'h5A5, "R4 gen zero");
        check("R4 literal", product, 12'h001);
        // R2: base-field overflow folds to x+1
        apply(1, 0, 12'h020, 12'h002, "R2 reduce");
        check("R2 literal", product, 12'h003);
        // R1 with heavy high digits
        apply(1, 0, 12'hFFF, 12'hFFF, "R1 all ones");
        apply(1, 0, 12'h800, 12'h040, "R1 high only");
        apply(1, 0, 12'hFC0, 12'h7C1, "R1 mixed");
        // R5 zero operands
        apply(1, 0, 0, 12'hABC, "R5 zero a");
        apply(1, 0, 12'h123, 0, "R5 zero b");
        check("R5 literal", product, 12'h000);
        // R6 identity
        apply(1, 0, 12'hD37, 1, "R6 identity");
        check("R6 literal", product, 12'hD37);
        apply(1, 0, 12'hFFF, 1, "R6 identity ones");
        // R3 generator step, op_b ignored
        apply(1, 1, 12'h001, 12'h000, "R3 gen one");
        check("R3 literal", product, 12'hE01);
        apply(1, 1, 12'h2B4, 12'h000, "R3 gen b0");
        keep = product;
        apply(1, 1, 12'h2B4, 12'hFFF, "R3 gen b1");
        check("R3 op_b ignored", product, keep);
        apply(1, 1, 0, 12'h777, "R4 gen zero mid");
        // R8 idle holds product, valid drops
        keep = product;
        apply(0, 0, 12'h111, 12'h222, "R8 idle1");
        apply(0, 1, 12'h333, 12'h444, "R8 idle2");
        check("R8 held", product, keep);
        // R7 commutativity
        apply(1, 0, 12'h9E3, 12'h46B, "R7 ab");
        keep = product;
        apply(1, 0, 12'h46B, 12'h9E3, "R7 ba");
        check("R7 commute", product, keep);

        // Random sweep, both modes, sporadic idle cycles (R1, R3, R8)
        for (int i = 0; i < 4000; i++) begin
            apply(($urandom % 8) != 0, $urandom % 2, $urandom % 4096,
                  $urandom % 4096, "R1 R3 random");
        end

        // R9 reset mid-stream
        in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R9 re-reset valid", {11'd0, out_valid}, 12'd0);
        check("R9 re-reset product", product, 12'd0);
        rst = 1'b0; exp_v = 1'b0; exp_p = '0;
        apply(1, 0, 12'h0C3, 12'h3C0, "R1 after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule